// File: doc/BRIEF.md
# Peripheral Register Completer with Wait States and Fault Response

This block is a small register file that answers the completer side of an APB transfer. A transfer starts with a setup cycle, where the select is high and the enable is low. It then has one or more access cycles, where both are high. The block holds a writable control word, a read-only status word taken from a hardware input, and a writable scratch word.

Each access phase is stretched by a fixed number of wait states, set by a parameter from 0 to 7. After that the block raises its ready output. Writes honour per-byte strobes. Accesses that must not succeed end with an error response and leave the registers unchanged. These are: an unmapped or misaligned address, a write to the status word, and a write to the control word without the privileged attribute.

Read data is returned only in the cycle that completes a good read, and is zero in every other cycle.

Top module: `apbreg_top`

## Requirements
- R1: While the synchronous active-high reset is asserted, the control and scratch words are cleared to zero. A read of either word after reset returns 0x00000000.
- R2: `ready_o` is low in every cycle where `sel_i` and `en_i` are not both high. Because of this, no transfer completes in fewer than two cycles.
- R3: In each access phase, `ready_o` stays low for exactly `WAIT_STATES` cycles and is high in the cycle after those.
- R4: On a write that completes without error, the bytes of `wdata_i` in lane k (bits 8k+7..8k) replace the target byte only where `strb_i[k]` is 1. Lanes whose strobe is 0 keep their old value.
- R5: The mapped word offsets are 0x0 (control), 0x4 (status) and 0x8 (scratch). Any other address, including a misaligned one, completes with `slverr_o` high and changes no register. A read of such an address returns 0.
- R6: A read of offset 0x4 returns `status_i`. A write to offset 0x4 completes with `slverr_o` high and changes no register.
- R7: A write to the control word with `priv_i` low completes with `slverr_o` high and leaves the control word unchanged. Reads of the control word, and writes to the scratch word, succeed regardless of `priv_i`.
- R8: `slverr_o` is high only in a completing cycle. `rdata_o` is non-zero only in the completing cycle of a read without error, and is zero otherwise.
- R9: A write to the control or scratch word that is allowed completes with `slverr_o` low. A later read returns the merged value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; everything is sampled on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Completer select (high in setup and access cycles) |
| en_i | input | 1 | Access-phase enable |
| wr_i | input | 1 | 1 = write transfer, 0 = read transfer |
| addr_i | input | ADDR_W | Byte address of the target word |
| wdata_i | input | 32 | Write data |
| strb_i | input | 4 | Byte-lane write strobes, bit k for bits 8k+7..8k |
| priv_i | input | 1 | Privileged-access attribute |
| status_i | input | 32 | Hardware value presented by the status word |
| rdata_o | output | 32 | Read data, valid in the completing cycle of a good read |
| ready_o | output | 1 | Completes the access phase when high |
| slverr_o | output | 1 | Error response in the completing cycle |

## Verification
The properties assume the requester follows the handshake. Every transfer opens with exactly one setup cycle. The enable rises only after that cycle. Address, direction, data, strobes and privilege stay fixed from setup until completion, and select and enable both drop in the cycle after completion.

The bench drives every transfer through one task that enforces this sequence on the falling clock edge. Between transfers it leaves a gap of at least one idle cycle, so the wait-state counter always starts an access phase from zero.

// File: rtl/apbreg_pkg.sv
package apbreg_pkg;

    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int STRB_W = DATA_W / LANE_W;

    typedef enum logic [1:0] {
        TGT_CTRL    = 2'd0,
        TGT_STATUS  = 2'd1,
        TGT_SCRATCH = 2'd2,
        TGT_NONE    = 2'd3
    } target_e;

    typedef struct packed {
        target_e tgt;
        logic    fault;
        logic    wr_ok;
    } decode_t;

    // Merge write data into an old word, one byte lane per strobe bit.
    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [STRB_W-1:0] strb
    );
        logic [DATA_W-1:0] res;
        res = old_w;
        for (int k = 0; k < STRB_W; k++) begin
            if (strb[k]) begin
                res[k*LANE_W +: LANE_W] = new_w[k*LANE_W +: LANE_W];
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/apbreg_decode.sv
module apbreg_decode
    import apbreg_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int CTRL_OFS    = 0,
    parameter int STATUS_OFS  = 4,
    parameter int SCRATCH_OFS = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              priv_i,
    output decode_t           dec_o
);

    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(SCRATCH_OFS);

    target_e tgt;

    always_comb begin
        if (addr_i == A_CTRL) begin
            tgt = TGT_CTRL;
        end else if (addr_i == A_STATUS) begin
            tgt = TGT_STATUS;
        end else if (addr_i == A_SCRATCH) begin
            tgt = TGT_SCRATCH;
        end else begin
            tgt = TGT_NONE;
        end
    end

    always_comb begin
        dec_o.tgt   = tgt;
        dec_o.fault = (tgt == TGT_NONE)
                    || (wr_i && (tgt == TGT_STATUS))
                    || (wr_i && (tgt == TGT_CTRL) && !priv_i);
        dec_o.wr_ok = wr_i && !dec_o.fault;
    end

endmodule

// File: rtl/apbreg_wait.sv
module apbreg_wait #(
    parameter int WAIT_STATES = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic access_i,
    output logic ready_o
);

    localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_STATES);

    logic [CNT_W-1:0] cnt_q;

    assign ready_o = access_i && (cnt_q == LIMIT);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (access_i && !ready_o) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/apbreg_bank.sv
module apbreg_bank
    import apbreg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  target_e           tgt_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STRB_W-1:0] strb_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] scratch_o,
    output logic [DATA_W-1:0] rd_word_o
);

    logic [DATA_W-1:0] ctrl_q, scratch_q;
    logic [DATA_W-1:0] ctrl_d, scratch_d;

    always_comb begin
        ctrl_d    = ctrl_q;
        scratch_d = scratch_q;
        if (we_i && (tgt_i == TGT_CTRL)) begin
            ctrl_d = lane_merge(ctrl_q, wdata_i, strb_i);
        end
        if (we_i && (tgt_i == TGT_SCRATCH)) begin
            scratch_d = lane_merge(scratch_q, wdata_i, strb_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q    <= '0;
            scratch_q <= '0;
        end else begin
            ctrl_q    <= ctrl_d;
            scratch_q <= scratch_d;
        end
    end

    always_comb begin
        unique case (tgt_i)
            TGT_CTRL:    rd_word_o = ctrl_q;
            TGT_STATUS:  rd_word_o = status_i;
            TGT_SCRATCH: rd_word_o = scratch_q;
            default:     rd_word_o = '0;
        endcase
    end

    assign ctrl_o    = ctrl_q;
    assign scratch_o = scratch_q;

endmodule

// File: rtl/apbreg_top.sv
module apbreg_top
    import apbreg_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int WAIT_STATES = 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sel_i,
    input  logic              en_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STRB_W-1:0] strb_i,
    input  logic              priv_i,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ready_o,
    output logic              slverr_o
);

    logic              access;
    logic              done;
    logic              we;
    decode_t           dec;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] ctrl_val;
    logic [DATA_W-1:0] scratch_val;

    assign access = sel_i && en_i;

    apbreg_wait #(
        .WAIT_STATES(WAIT_STATES)
    ) u_wait (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .access_i(access),
        .ready_o (ready_o)
    );

    apbreg_decode #(
        .ADDR_W(ADDR_W)
    ) u_dec (
        .addr_i(addr_i),
        .wr_i  (wr_i),
        .priv_i(priv_i),
        .dec_o (dec)
    );

    assign done = access && ready_o;
    assign we   = done && dec.wr_ok;

    apbreg_bank u_bank (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .we_i     (we),
        .tgt_i    (dec.tgt),
        .wdata_i  (wdata_i),
        .strb_i   (strb_i),
        .status_i (status_i),
        .ctrl_o   (ctrl_val),
        .scratch_o(scratch_val),
        .rd_word_o(rd_word)
    );

    assign rdata_o  = (done && !wr_i && !dec.fault) ? rd_word : '0;
    assign slverr_o = done && dec.fault;

endmodule

// File: rtl/apbreg_checker.sv
module apbreg_checker #(
    parameter int WAIT_STATES = 1
) (
    input logic        clk_i,
    input logic        rst_i,
    input logic        sel_i,
    input logic        en_i,
    input logic        wr_i,
    input logic        priv_i,
    input logic        ready_o,
    input logic        slverr_o,
    input logic [31:0] rdata_o,
    input logic [31:0] ctrl_val,
    input logic [31:0] scratch_val
);

    int unsigned stall_cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stall_cnt <= 0;
        end else if (sel_i && en_i && !ready_o) begin
            stall_cnt <= stall_cnt + 1;
        end else begin
            stall_cnt <= 0;
        end
    end

    p_ready_in_access_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> (sel_i && en_i));

    p_wait_exact_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i && en_i && ready_o) |-> (stall_cnt == WAIT_STATES));

    p_wait_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i && en_i && !ready_o) |-> (stall_cnt < WAIT_STATES));

    p_no_change_idle_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !(sel_i && en_i && ready_o && wr_i) |=> ($stable(ctrl_val) && $stable(scratch_val)));

    p_fault_no_update_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        slverr_o |=> ($stable(ctrl_val) && $stable(scratch_val)));

    p_unpriv_ctrl_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i && en_i && ready_o && wr_i && !priv_i) |=> $stable(ctrl_val));

    p_err_on_done_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        slverr_o |-> ready_o);

    p_rdata_quiet_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdata_o != 32'd0) |-> (ready_o && !wr_i && !slverr_o));

endmodule

bind apbreg_top apbreg_checker #(
    .WAIT_STATES(WAIT_STATES)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sel_i      (sel_i),
    .en_i       (en_i),
    .wr_i       (wr_i),
    .priv_i     (priv_i),
    .ready_o    (ready_o),
    .slverr_o   (slverr_o),
    .rdata_o    (rdata_o),
    .ctrl_val   (ctrl_val),
    .scratch_val(scratch_val)
);

// File: tb/tb_apbreg_top.sv
`timescale 1ns/1ps
module tb_apbreg_top;

    localparam int WAITS  = 3;
    localparam int ADDR_W = 12;
    localparam logic [31:0] STAT = 32'hA5C3_0F12;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [3:0]  strb;
        logic        priv;
        logic        exp_err;
        logic [31:0] exp_rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 12'h000, 32'h1122_3344, 4'hF, 1'b1, 1'b0, 32'h0,         4'd9}, // R9
        '{1'b0, 12'h000, 32'h0,         4'h0, 1'b1, 1'b0, 32'h1122_3344, 4'd9}, // R9
        '{1'b1, 12'h000, 32'hAABB_CCDD, 4'h5, 1'b1, 1'b0, 32'h0,         4'd4}, // R4
        '{1'b0, 12'h000, 32'h0,         4'h0, 1'b1, 1'b0, 32'h11BB_33DD, 4'd4}, // R4
        '{1'b1, 12'h000, 32'h0,         4'hF, 1'b0, 1'b1, 32'h0,         4'd7}, // R7
        '{1'b0, 12'h000, 32'h0,         4'h0, 1'b0, 1'b0, 32'h11BB_33DD, 4'd7}, // R7
        '{1'b1, 12'h008, 32'hCAFE_F00D, 4'hA, 1'b0, 1'b0, 32'h0,         4'd7}, // R7
        '{1'b0, 12'h008, 32'h0,         4'h0, 1'b1, 1'b0, 32'hCA00_F000, 4'd4}, // R4
        '{1'b1, 12'h004, 32'hFFFF_FFFF, 4'hF, 1'b1, 1'b1, 32'h0,         4'd6}, // R6
        '{1'b0, 12'h004, 32'h0,         4'h0, 1'b1, 1'b0, STAT,          4'd6}, // R6
        '{1'b1, 12'h00C, 32'hFFFF_FFFF, 4'hF, 1'b1, 1'b1, 32'h0,         4'd5}, // R5
        '{1'b0, 12'h00C, 32'h0,         4'h0, 1'b1, 1'b1, 32'h0,         4'd5}, // R5
        '{1'b0, 12'h000, 32'h0,         4'h0, 1'b1, 1'b0, 32'h11BB_33DD, 4'd5}, // R5
        '{1'b0, 12'h008, 32'h0,         4'h0, 1'b1, 1'b0, 32'hCA00_F000, 4'd6}, // R6
        '{1'b1, 12'h00A, 32'h1234_5678, 4'hF, 1'b1, 1'b1, 32'h0,         4'd5}, // R5
        '{1'b0, 12'h008, 32'h0,         4'h0, 1'b1, 1'b0, 32'hCA00_F000, 4'd5}  // R5
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, en = 1'b0, wr = 1'b0, priv = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  strb = '0;
    logic [31:0] status = STAT;
    logic [31:0] rdata;
    logic        ready, slverr;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    apbreg_top #(
        .ADDR_W(ADDR_W),
        .WAIT_STATES(WAITS)
    ) dut (
        .clk_i(clk), .rst_i(rst), .sel_i(sel), .en_i(en), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .strb_i(strb), .priv_i(priv),
        .status_i(status), .rdata_o(rdata), .ready_o(ready), .slverr_o(slverr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input vec_t v, output logic [31:0] rd, output logic err, output int waits);
        @(negedge clk);
        sel = 1'b1; en = 1'b0; wr = v.wr; addr = v.addr;
        wdata = v.wdata; strb = v.strb; priv = v.priv;
        #1;
        check("R2 ready low in setup", {31'd0, ready}, 32'd0);
        @(negedge clk);
        en = 1'b1;
        waits = 0;
        #1;
        while (!ready && waits < 40) begin
            check("R8 rdata zero while stalled", rdata, 32'd0);
            @(negedge clk);
            #1;
            waits++;
        end
        rd  = rdata;
        err = slverr;
        @(negedge clk);
        sel = 1'b0; en = 1'b0; wr = 1'b0; strb = '0;
        #1;
        check("R8 idle after done", {rdata[30:0] | {31{ready}}, slverr}, 32'd0);
    endtask

    function automatic vec_t rd_vec(input logic [11:0] a);
        vec_t v;
        v = '0;
        v.addr = a;
        v.priv = 1'b1;
        return v;
    endfunction

    initial begin
        logic [31:0] rd;
        logic        err;
        int          waits;
        repeat (3) @(negedge clk);
        #1;
        check("R8 idle rdata after reset", rdata, 32'd0);
        check("R2 idle ready", {31'd0, ready}, 32'd0);
        rst = 1'b0;

        // R1: reset state of the writable words
        xfer(rd_vec(12'h000), rd, err, waits);
        check("R1 ctrl after reset", rd, 32'd0);
        xfer(rd_vec(12'h008), rd, err, waits);
        check("R1 scratch after reset", rd, 32'd0);
        check("R3 wait count", waits, WAITS);

        for (int i = 0; i < NVEC; i++) begin
            xfer(VECS[i], rd, err, waits);
            tests++;
            if (err !== VECS[i].exp_err) begin
                fails++;
                $display("FAIL R%0d vec %0d err actual=%b expected=%b",
                         VECS[i].req, i, err, VECS[i].exp_err);
            end
            tests++;
            if (rd !== VECS[i].exp_rd) begin
                fails++;
                $display("FAIL R%0d vec %0d rdata actual=%h expected=%h",
                         VECS[i].req, i, rd, VECS[i].exp_rd);
            end
            check("R3 wait states per access", waits, WAITS);
        end

        // R6: status follows the hardware input
        status = 32'h0000_0001;
        xfer(rd_vec(12'h004), rd, err, waits);
        check("R6 status follows input", rd, 32'h0000_0001);

        // R4: zero strobes leave the word unchanged
        begin
            vec_t v;
            v = rd_vec(12'h008);
            v.wr = 1'b1; v.wdata = 32'hFFFF_FFFF; v.strb = 4'h0;
            xfer(v, rd, err, waits);
            check("R4 zero strobe no error", {31'd0, err}, 32'd0);
        end
        xfer(rd_vec(12'h008), rd, err, waits);
        check("R4 zero strobe keeps scratch", rd, 32'hCA00_F000);

        // R1: reset mid-run clears the writable words
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        xfer(rd_vec(12'h000), rd, err, waits);
        check("R1 ctrl cleared by reset", rd, 32'd0);
        xfer(rd_vec(12'h008), rd, err, waits);
        check("R1 scratch cleared by reset", rd, 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule